// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the register-access front end of one interrupt controller with up to eight request lines. Software talks to it through two byte-wide write ports: a command port and a data port, each qualified by its own write strobe. From the stream of bytes it works out which words start an initialization sequence and which are operation commands. It keeps the configuration a priority resolver downstream consumes: the per-line mask, the interrupt vector base, the auto end-of-interrupt flag, the special mode flag and the register-select bit for status reads.

The data port has two roles. While an initialization sequence is running, a small word counter steers each data byte to the next configuration field: first the vector base, then the cascade word, and optionally a final mode word. Bit 0 of the starting command byte decides whether that mode word is expected. When no sequence is running, data bytes load the mask. A busy output marks the running sequence. A sticky error flag reports requests for operating modes the block does not implement.

Priority resolution and vector delivery live elsewhere. This block only publishes its state and a per-line vector, which is the base plus the line number.

Top module: `irqc_init_seq`

## Requirements
- R1: After reset the mask is all ones, the vector base is 0x00, and `auto_eoi`, `special_mode`, `rd_isr`, `init_busy` and `mode_err` are all 0.
- R2: A command-port byte with bit 4 set starts initialization. From the next cycle `init_busy` is 1, and `auto_eoi`, `special_mode` and `rd_isr` are 0. The first data byte after it loads the vector base.
- R3: If bit 0 of the starting byte is 0, the sequence takes two data bytes (base, cascade) and `init_busy` falls after the second. If bit 0 is 1, it takes three (base, cascade, mode) and falls after the third. The cascade byte changes no output.
- R4: A starting byte with any of bits 1, 2, 3, 5, 6 or 7 set sets `mode_err`. A starting byte with none of them set clears `mode_err`.
- R5: In the mode byte, bit 1 sets `auto_eoi`. Bit 0 clear or bit 4 set sets `mode_err`.
- R6: A data byte written while `init_busy` is 0 loads the mask (bit n masks line n). Data bytes taken by a sequence leave the mask unchanged.
- R7: The vector for line n is (base + n) modulo 256 and appears on `line_vec[8n+7:8n]`.
- R8: A command byte with bit 4 clear and bit 3 set is a status/mode command. Bit 6 set copies bit 5 into `special_mode`. Bit 1 set copies bit 0 into `rd_isr`. Bit 2 set (poll) sets `mode_err`.
- R9: A command byte with bits 4 and 3 both clear changes no output.
- R10: When both strobes are active in the same cycle, the command byte is processed and the data byte is dropped.
- R11: A starting byte that arrives during a sequence restarts it, so the next data byte loads the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| wdata | input | 8 | Byte written on either port |
| mask | output | LINES | Per-line mask, 1 = masked |
| line_vec | output | LINES*VEC_W | Vector for each line, line 0 in the low byte |
| auto_eoi | output | 1 | Auto end-of-interrupt enabled |
| special_mode | output | 1 | Special mode enabled |
| rd_isr | output | 1 | Status reads select in-service register |
| init_busy | output | 1 | Initialization sequence in progress |
| mode_err | output | 1 | Unsupported mode was requested |

## Verification
Nearly every fault here is a wrong word index. An index that is off by one sends a vector byte into the mask, or a mask byte into the base. Because every register updates on the edge of the write, this shows on `mask` or `line_vec` one cycle after the stray byte. A sequence-length fault keeps `init_busy` high, or drops it, one write away from the expected point. The next idle data byte then lands in the wrong place, so the bench follows each such sequence with a mask write. Error-flag faults show on `mode_err` one cycle after the offending byte.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [1:0] {
      CMD_START  = 2'd0,
      CMD_STATUS = 2'd1,
      CMD_OTHER  = 2'd2
   } cmd_kind_e;

   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_BASE = 2'd1,
      STEP_CASC = 2'd2,
      STEP_MODE = 2'd3
   } step_e;

   function automatic cmd_kind_e decode_cmd(input logic [7:0] w);
      if (w[4])      return CMD_START;
      else if (w[3]) return CMD_STATUS;
      else           return CMD_OTHER;
   endfunction

   function automatic logic start_unsupported(input logic [7:0] w);
      return (|w[7:5]) | (|w[3:1]);
   endfunction

   function automatic logic mode_unsupported(input logic [7:0] w);
      return ~w[0] | w[4];
   endfunction

endpackage

// File: rtl/irqc_seq_ctrl.sv
module irqc_seq_ctrl
   import irqc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  want_mode,
   input  logic  data_wr,
   output step_e step
);

   logic has_mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step       <= STEP_IDLE;
         has_mode_q <= 1'b0;
      end else if (start) begin
         step       <= STEP_BASE;
         has_mode_q <= want_mode;
      end else if (data_wr) begin
         case (step)
            STEP_BASE: step <= STEP_CASC;
            STEP_CASC: step <= has_mode_q ? STEP_MODE : STEP_IDLE;
            STEP_MODE: step <= STEP_IDLE;
            default:   step <= STEP_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
   import irqc_pkg::*;
#(
   parameter int unsigned LINES = 8,
   parameter int unsigned VEC_W = 8,
   parameter logic [LINES-1:0] MASK_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  cmd_kind_e        kind,
   input  logic             data_wr,
   input  step_e            step,
   input  logic [7:0]       wdata,
   output logic [LINES-1:0] mask_q,
   output logic [VEC_W-1:0] base_q,
   output logic             aeoi_q,
   output logic             spec_q,
   output logic             rd_isr_q,
   output logic             err_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= MASK_RST;
         base_q   <= '0;
         aeoi_q   <= 1'b0;
         spec_q   <= 1'b0;
         rd_isr_q <= 1'b0;
         err_q    <= 1'b0;
      end else if (cmd_wr) begin
         case (kind)
            CMD_START: begin
               err_q    <= start_unsupported(wdata);
               aeoi_q   <= 1'b0;
               spec_q   <= 1'b0;
               rd_isr_q <= 1'b0;
            end
            CMD_STATUS: begin
               if (wdata[6]) spec_q   <= wdata[5];
               if (wdata[1]) rd_isr_q <= wdata[0];
               if (wdata[2]) err_q    <= 1'b1;
            end
            default: ;
         endcase
      end else if (data_wr) begin
         case (step)
            STEP_IDLE: mask_q <= wdata[LINES-1:0];
            STEP_BASE: base_q <= wdata[VEC_W-1:0];
            STEP_MODE: begin
               aeoi_q <= wdata[1];
               if (mode_unsupported(wdata)) err_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/irqc_vec_gen.sv
module irqc_vec_gen #(
   parameter int unsigned LINES = 8,
   parameter int unsigned VEC_W = 8,
   parameter bit          ALIGN = 1'b0
) (
   input  logic [VEC_W-1:0]       base,
   output logic [LINES*VEC_W-1:0] line_vec
);

   logic [VEC_W-1:0] base_eff;

   generate
      if (ALIGN) begin : g_align
         localparam logic [VEC_W-1:0] LOW_BITS = VEC_W'(LINES - 1);
         assign base_eff = base & ~LOW_BITS;
      end else begin : g_plain
         assign base_eff = base;
      end

      for (genvar n = 0; n < LINES; n++) begin : g_line
         assign line_vec[n*VEC_W +: VEC_W] = base_eff + VEC_W'(n);
      end
   endgenerate

endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
   import irqc_pkg::*;
#(
   parameter int unsigned LINES      = 8,
   parameter int unsigned VEC_W      = 8,
   parameter bit          BASE_ALIGN = 1'b0,
   parameter logic [LINES-1:0] MASK_RST = '1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_we,
   input  logic                   data_we,
   input  logic [7:0]             wdata,
   output logic [LINES-1:0]       mask,
   output logic [LINES*VEC_W-1:0] line_vec,
   output logic                   auto_eoi,
   output logic                   special_mode,
   output logic                   rd_isr,
   output logic                   init_busy,
   output logic                   mode_err
);

   generate
      if (LINES < 1 || LINES > 8) begin : g_bad_lines
         $error("irqc_init_seq: LINES must be 1..8");
      end
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vecw
         $error("irqc_init_seq: VEC_W must be 1..8");
      end
      if (LINES > (1 << VEC_W)) begin : g_bad_fit
         $error("irqc_init_seq: LINES exceeds vector range");
      end
   endgenerate

   cmd_kind_e        kind;
   step_e            step;
   logic             data_wr;
   logic             start;
   logic [VEC_W-1:0] base;

   assign kind    = decode_cmd(wdata);
   assign data_wr = data_we & ~cmd_we;
   assign start   = cmd_we & (kind == CMD_START);

   irqc_seq_ctrl u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .want_mode (wdata[0]),
      .data_wr   (data_wr),
      .step      (step)
   );

   irqc_cfg_regs #(
      .LINES    (LINES),
      .VEC_W    (VEC_W),
      .MASK_RST (MASK_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_we),
      .kind     (kind),
      .data_wr  (data_wr),
      .step     (step),
      .wdata    (wdata),
      .mask_q   (mask),
      .base_q   (base),
      .aeoi_q   (auto_eoi),
      .spec_q   (special_mode),
      .rd_isr_q (rd_isr),
      .err_q    (mode_err)
   );

   irqc_vec_gen #(
      .LINES (LINES),
      .VEC_W (VEC_W),
      .ALIGN (BASE_ALIGN)
   ) u_vec (
      .base     (base),
      .line_vec (line_vec)
   );

   assign init_busy = (step != STEP_IDLE);

endmodule

// File: rtl/irqc_init_seq_chk.sv
module irqc_init_seq_chk #(
   parameter int unsigned LINES = 8,
   parameter int unsigned VEC_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_we,
   input logic                   data_we,
   input logic [7:0]             wdata,
   input logic [LINES-1:0]       mask,
   input logic [LINES*VEC_W-1:0] line_vec,
   input logic                   auto_eoi,
   input logic                   special_mode,
   input logic                   rd_isr,
   input logic                   init_busy,
   input logic                   mode_err
);

   logic bad_start;
   assign bad_start = (|wdata[7:5]) | (|wdata[3:1]);

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && wdata[4] |=> init_busy && !special_mode && !rd_isr);

   assert_bad_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && wdata[4] && bad_start |=> mode_err);

   assert_clean_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && wdata[4] && !bad_start |=> !mode_err);

   assert_start_aeoi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && wdata[4] |=> !auto_eoi);

   assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !init_busy && data_we && !cmd_we |=> mask == $past(wdata[LINES-1:0]));

   assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy && data_we && !cmd_we |=> $stable(mask));

   assert_poll_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && wdata[4:2] == 3'b011 |=> mode_err);

   assert_other_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && wdata[4:3] == 2'b00 |=> $stable(mask) && $stable(line_vec)
         && $stable(auto_eoi) && $stable(special_mode) && $stable(rd_isr)
         && $stable(init_busy) && $stable(mode_err));

   assert_data_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && data_we |=> $stable(mask));

   generate
      if (LINES > 1) begin : g_vec_chk
         assert_vec_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            line_vec[VEC_W +: VEC_W] == line_vec[0 +: VEC_W] + VEC_W'(1));
      end
   endgenerate

endmodule

bind irqc_init_seq irqc_init_seq_chk #(
   .LINES (LINES),
   .VEC_W (VEC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_we       (cmd_we),
   .data_we      (data_we),
   .wdata        (wdata),
   .mask         (mask),
   .line_vec     (line_vec),
   .auto_eoi     (auto_eoi),
   .special_mode (special_mode),
   .rd_isr       (rd_isr),
   .init_busy    (init_busy),
   .mode_err     (mode_err)
);

// File: tb/irqc_init_seq_tb.sv
module irqc_init_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic        data_we = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  mask;
   logic [63:0] line_vec;
   logic        auto_eoi, special_mode, rd_isr, init_busy, mode_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irqc_init_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_we       (cmd_we),
      .data_we      (data_we),
      .wdata        (wdata),
      .mask         (mask),
      .line_vec     (line_vec),
      .auto_eoi     (auto_eoi),
      .special_mode (special_mode),
      .rd_isr       (rd_isr),
      .init_busy    (init_busy),
      .mode_err     (mode_err)
   );

   // entry: {req[3:0], is_data, wdata, exp_mask, exp_base, flags{busy,aeoi,err,spec}}
   localparam int NV = 24;
   localparam logic [32:0] VECS [NV] = '{
      {4'd6,  1'b1, 8'h5A, 8'h5A, 8'h00, 4'b0000},  // R6 idle mask load
      {4'd2,  1'b0, 8'h11, 8'h5A, 8'h00, 4'b1000},  // R2 start, mode word expected
      {4'd2,  1'b1, 8'h20, 8'h5A, 8'h20, 4'b1000},  // R2 base
      {4'd3,  1'b1, 8'h04, 8'h5A, 8'h20, 4'b1000},  // R3 cascade, still busy
      {4'd5,  1'b1, 8'h03, 8'h5A, 8'h20, 4'b0100},  // R5 mode word sets aeoi
      {4'd6,  1'b1, 8'hF0, 8'hF0, 8'h20, 4'b0100},  // R6 mask again
      {4'd5,  1'b0, 8'h10, 8'hF0, 8'h20, 4'b1000},  // R5 start clears aeoi
      {4'd2,  1'b1, 8'h48, 8'hF0, 8'h48, 4'b1000},  // R2 base
      {4'd3,  1'b1, 8'h00, 8'hF0, 8'h48, 4'b0000},  // R3 short sequence ends
      {4'd8,  1'b0, 8'h68, 8'hF0, 8'h48, 4'b0001},  // R8 special mode on
      {4'd9,  1'b0, 8'h20, 8'hF0, 8'h48, 4'b0001},  // R9 other command ignored
      {4'd8,  1'b0, 8'h0C, 8'hF0, 8'h48, 4'b0011},  // R8 poll -> error
      {4'd4,  1'b0, 8'h12, 8'hF0, 8'h48, 4'b1010},  // R4 single mode -> error
      {4'd11, 1'b0, 8'h10, 8'hF0, 8'h48, 4'b1000},  // R11 restart mid sequence
      {4'd11, 1'b1, 8'h80, 8'hF0, 8'h80, 4'b1000},  // R11 base after restart
      {4'd3,  1'b1, 8'h00, 8'hF0, 8'h80, 4'b0000},  // R3
      {4'd2,  1'b0, 8'h11, 8'hF0, 8'h80, 4'b1000},  // R2
      {4'd2,  1'b1, 8'h08, 8'hF0, 8'h08, 4'b1000},  // R2
      {4'd3,  1'b1, 8'h00, 8'hF0, 8'h08, 4'b1000},  // R3
      {4'd5,  1'b1, 8'h13, 8'hF0, 8'h08, 4'b0110},  // R5 nested bit -> error
      {4'd6,  1'b1, 8'h01, 8'h01, 8'h08, 4'b0110},  // R6
      {4'd4,  1'b0, 8'h90, 8'h01, 8'h08, 4'b1010},  // R4 bit 7 -> error
      {4'd4,  1'b1, 8'h33, 8'h01, 8'h33, 4'b1010},  // R4
      {4'd3,  1'b1, 8'h00, 8'h01, 8'h33, 4'b0010}   // R3
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit is_data, input logic [7:0] v);
      @(negedge clk);
      cmd_we  = !is_data;
      data_we = is_data;
      wdata   = v;
      @(negedge clk);
      cmd_we  = 1'b0;
      data_we = 1'b0;
   endtask

   function automatic logic [63:0] exp_lines(input logic [7:0] b);
      logic [63:0] r;
      for (int n = 0; n < 8; n++) r[n*8 +: 8] = b + 8'(n);
      return r;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mask", {56'd0, mask}, 64'hFF);
      check("R1 flags", {59'd0, init_busy, auto_eoi, mode_err, special_mode, rd_isr}, 64'd0);
      check("R1/R7 vectors", line_vec, exp_lines(8'h00));

      for (int i = 0; i < NV; i++) begin
         logic [32:0] e;
         string tag;
         e = VECS[i];
         wr(e[28], e[27:20]);
         tag = $sformatf("R%0d entry %0d", e[32:29], i);
         check(tag, {32'd0, mask, line_vec[7:0], init_busy, auto_eoi, mode_err, special_mode, 12'd0},
               {32'd0, e[19:12], e[11:4], e[3:0], 12'd0});
      end

      // R8 register select
      wr(1'b0, 8'h0B);
      check("R8 rd_isr set", {63'd0, rd_isr}, 64'd1);
      wr(1'b0, 8'h09);
      check("R8 rd_isr held when bit1 clear", {63'd0, rd_isr}, 64'd1);
      wr(1'b0, 8'h0A);
      check("R8 rd_isr cleared", {63'd0, rd_isr}, 64'd0);
      wr(1'b0, 8'h0B);
      wr(1'b0, 8'h10);
      check("R2 start clears rd_isr", {62'd0, rd_isr, init_busy}, 64'd1);

      // R7 wrap of vectors
      wr(1'b1, 8'hFC);
      wr(1'b1, 8'h00);
      check("R7 vectors wrap", line_vec, exp_lines(8'hFC));
      check("R3 idle after short sequence", {63'd0, init_busy}, 64'd0);

      // R10 both strobes: data dropped, other command processed (no effect)
      @(negedge clk);
      cmd_we = 1'b1; data_we = 1'b1; wdata = 8'h20;
      @(negedge clk);
      cmd_we = 1'b0; data_we = 1'b0;
      check("R10 mask unchanged", {56'd0, mask}, 64'h01);
      wr(1'b1, 8'h3C);
      check("R10 next idle write loads mask", {56'd0, mask}, 64'h3C);

      // R10 both strobes with a start byte: sequence begins, data not used as base
      @(negedge clk);
      cmd_we = 1'b1; data_we = 1'b1; wdata = 8'h10;
      @(negedge clk);
      cmd_we = 1'b0; data_we = 1'b0;
      check("R10 start wins, base kept", {55'd0, init_busy, line_vec[7:0]}, {55'd0, 1'b1, 8'hFC});
      wr(1'b1, 8'h40);
      check("R10 next data is base", {56'd0, line_vec[7:0]}, 64'h40);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule